// File: doc/BRIEF.md
# Window limit monitor

The block watches a stream of signed 16-bit conversion results, each tagged with the index of the channel that produced it, and checks each one against a pair of limits held for that channel. A result at or above the channel's upper limit latches an upper-limit event; a result at or below its lower limit latches a lower-limit event. Up to eight channels are supported, so there are sixteen event flags.

Software side: one limit word per channel is written through a channel-addressed write port and can be read back through a channel-addressed read port. The event flags can be written one at a time, which is how they are cleared. A 32-bit interrupt-enable word can be written directly, have bits set by writing ones, or have bits cleared by writing ones. The interrupt output is high whenever any flag is set and its enable bit is set.

Top module: `window_limit_monitor`

## Requirements
- R1: A limit word holds the lower limit in bits 15:0 and the upper limit in bits 31:16, both signed; a write to channel c is returned unchanged by the read port for channel c from the next cycle on.
- R2: After reset every limit word reads 0x7FFF8000 (upper +32767, lower -32768), no event flag is set, the enable word reads zero and the interrupt is low.
- R3: The upper-limit flag of the channel is set when the result is greater than or equal to that channel's upper limit; a result one below it leaves the flag clear.
- R4: The lower-limit flag of the channel is set when the result is less than or equal to that channel's lower limit; a result one above it leaves the flag clear.
- R5: A result only affects the two flags of the channel named by its index; flag bit 2c is channel c upper, bit 2c+1 is channel c lower.
- R6: Flags are sticky: a later result inside the window leaves them set; a flag write with value 0 clears the addressed flag, value 1 sets it, and a hardware set in the same cycle as a clearing write leaves the flag set.
- R7: Limits with lower above upper are compared literally: a value between them sets both flags; the window never turns into an inside-range detector.
- R8: Enable bit 6+k belongs to flag k (channel 0 upper at bit 6, channel 0 lower at bit 7, up to channel 7 lower at bit 21); all other enable bits read as zero.
- R9: The direct enable write is applied first, then the set mask ORed in, then the clear mask removed, all in one cycle.
- R10: The interrupt is the OR over all flags of flag AND enable, following flag and enable changes in the same cycle they become visible.
- R11: Flags change one clock after a result strobe; with the strobe low, result and index have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_vld_i | input | 1 | Result strobe |
| res_ch_i | input | 3 | Channel index of the result |
| res_data_i | input | 16 | Signed result |
| lim_we_i | input | 1 | Limit word write strobe |
| lim_ch_i | input | 3 | Channel addressed by the limit write |
| lim_wdata_i | input | 32 | Limit word: upper 31:16, lower 15:0 |
| rd_ch_i | input | 3 | Channel selected for limit readback |
| rd_limit_o | output | 32 | Limit word of the selected channel |
| evt_we_i | input | 1 | Flag write strobe |
| evt_idx_i | input | 4 | Flag index, 2c upper, 2c+1 lower |
| evt_wdata_i | input | 1 | Value written to the addressed flag |
| evt_o | output | 16 | All event flags |
| en_we_i | input | 1 | Direct enable write strobe |
| en_wdata_i | input | 32 | Direct enable value |
| en_set_i | input | 32 | Ones set enable bits |
| en_clr_i | input | 32 | Ones clear enable bits |
| en_o | output | 32 | Enable word |
| irq_o | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check that a hardware set lands in its flag one cycle later, that a flag never rises without a set or a write of one, that no result touches more than one channel's flag pair, that cleared enable bits are gone the next cycle, that a written limit is held, and that the interrupt only rises with some flag and some enable present. The inclusive thresholds, the inverted-window behaviour, the reset limits at both ends of the signed range and the enable bit placement are only shown by the bench, which sweeps results across each channel's limits and compares the flags and the interrupt with values it computes from the limits.

// File: rtl/wlm_pkg.sv
package wlm_pkg;
  localparam int DATA_W = 16;
  typedef logic signed [DATA_W-1:0] sample_t;
  typedef struct packed {
    sample_t hi;
    sample_t lo;
  } limit_t;
  localparam sample_t SAMPLE_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam sample_t SAMPLE_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam limit_t LIMIT_RST = '{hi: SAMPLE_MAX, lo: SAMPLE_MIN};
endpackage

// File: rtl/wlm_chan.sv
module wlm_chan
  import wlm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    lim_we_i,
  input  limit_t  lim_wdata_i,
  input  logic    sel_i,
  input  sample_t res_i,
  output limit_t  limit_o,
  output logic    hit_hi_o,
  output logic    hit_lo_o
);
  limit_t limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       limit_q <= LIMIT_RST;
    else if (lim_we_i) limit_q <= lim_wdata_i;
  end

  // inclusive on both sides, no ordering check between hi and lo
  assign hit_hi_o = sel_i && (res_i >= limit_q.hi);
  assign hit_lo_o = sel_i && (res_i <= limit_q.lo);
  assign limit_o  = limit_q;

  assert_limit_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_we_i |=> (limit_o == $past(lim_wdata_i)));
endmodule

// File: rtl/wlm_evt_flags.sv
module wlm_evt_flags #(
  parameter int NEV   = 16,
  localparam int IDX_W = (NEV > 1) ? $clog2(NEV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NEV-1:0]   set_i,
  input  logic             sw_we_i,
  input  logic [IDX_W-1:0] sw_idx_i,
  input  logic             sw_val_i,
  output logic [NEV-1:0]   flags_o
);
  logic [NEV-1:0] flags_q;

  for (genvar k = 0; k < NEV; k++) begin : g_flag
    logic sw_hit;
    assign sw_hit = sw_we_i && (int'(sw_idx_i) == k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_q[k] <= 1'b0;
      else if (set_i[k])  flags_q[k] <= 1'b1;  // hardware wins over software
      else if (sw_hit)    flags_q[k] <= sw_val_i;
    end

    assert_set_lands_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flags_q[k]);
    assert_rise_has_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_q[k]) |-> $past(set_i[k] || (sw_hit && sw_val_i)));
    assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[k] && !(sw_hit && !sw_val_i)) |=> flags_q[k]);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/wlm_inten.sv
module wlm_inten #(
  parameter int REG_W    = 32,
  parameter int EVT_BASE = 6,
  parameter int NEV      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [NEV-1:0]   en_o
);
  logic [NEV-1:0] en_q, en_d, wr_s, set_s, clr_s;

  assign wr_s  = wdata_i[EVT_BASE +: NEV];
  assign set_s = set_i[EVT_BASE +: NEV];
  assign clr_s = clr_i[EVT_BASE +: NEV];

  // order: direct write, then set, then clear
  always_comb begin
    en_d = we_i ? wr_s : en_q;
    en_d = en_d | set_s;
    en_d = en_d & ~clr_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  assert_clr_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_s) |=> ((en_q & $past(clr_s)) == '0));
  assert_set_applied_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_s & ~clr_s)) |=> ((en_q & $past(set_s & ~clr_s)) == $past(set_s & ~clr_s)));
endmodule

// File: rtl/window_limit_monitor.sv
module window_limit_monitor
  import wlm_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int REG_W    = 32,
  parameter int EVT_BASE = 6,
  localparam int NEV     = 2 * NUM_CH,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W   = (NEV > 1) ? $clog2(NEV) : 1,
  localparam int LIM_W   = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_vld_i,
  input  logic [CH_W-1:0]   res_ch_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              lim_we_i,
  input  logic [CH_W-1:0]   lim_ch_i,
  input  logic [LIM_W-1:0]  lim_wdata_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [LIM_W-1:0]  rd_limit_o,
  input  logic              evt_we_i,
  input  logic [IDX_W-1:0]  evt_idx_i,
  input  logic              evt_wdata_i,
  output logic [NEV-1:0]    evt_o,
  input  logic              en_we_i,
  input  logic [REG_W-1:0]  en_wdata_i,
  input  logic [REG_W-1:0]  en_set_i,
  input  logic [REG_W-1:0]  en_clr_i,
  output logic [REG_W-1:0]  en_o,
  output logic              irq_o
);
  limit_t         limits [NUM_CH];
  logic [NEV-1:0] set_vec;
  logic [NEV-1:0] flags;
  logic [NEV-1:0] en;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel, we;
    assign sel = res_vld_i && (int'(res_ch_i) == c);
    assign we  = lim_we_i && (int'(lim_ch_i) == c);

    wlm_chan u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lim_we_i    (we),
      .lim_wdata_i (limit_t'(lim_wdata_i)),
      .sel_i       (sel),
      .res_i       (sample_t'(res_data_i)),
      .limit_o     (limits[c]),
      .hit_hi_o    (set_vec[2*c]),
      .hit_lo_o    (set_vec[2*c+1])
    );
  end

  wlm_evt_flags #(.NEV(NEV)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .sw_we_i  (evt_we_i),
    .sw_idx_i (evt_idx_i),
    .sw_val_i (evt_wdata_i),
    .flags_o  (flags)
  );

  wlm_inten #(.REG_W(REG_W), .EVT_BASE(EVT_BASE), .NEV(NEV)) u_inten (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (en_we_i),
    .wdata_i (en_wdata_i),
    .set_i   (en_set_i),
    .clr_i   (en_clr_i),
    .en_o    (en)
  );

  always_comb begin
    en_o = '0;
    en_o[EVT_BASE +: NEV] = en;
  end

  assign rd_limit_o = (int'(rd_ch_i) < NUM_CH) ? LIM_W'(limits[rd_ch_i]) : '0;
  assign evt_o      = flags;
  assign irq_o      = |(flags & en);

  assert_one_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(set_vec) <= 2);
  assert_irq_has_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|evt_o) && (|en_o)));
  assert_quiet_no_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_i |-> (set_vec == '0));
endmodule

// File: tb/window_limit_monitor_tb.sv
module window_limit_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int NEV = 2 * NCH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_vld = 1'b0;
  logic [2:0]  res_ch = '0;
  logic [15:0] res_data = '0;
  logic        lim_we = 1'b0;
  logic [2:0]  lim_ch = '0;
  logic [31:0] lim_wdata = '0;
  logic [2:0]  rd_ch = '0;
  logic [31:0] rd_limit;
  logic        evt_we = 1'b0;
  logic [3:0]  evt_idx = '0;
  logic        evt_wdata = 1'b0;
  logic [15:0] evt;
  logic        en_we = 1'b0;
  logic [31:0] en_wdata = '0, en_set = '0, en_clr = '0;
  logic [31:0] en_word;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  window_limit_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .res_vld_i(res_vld), .res_ch_i(res_ch), .res_data_i(res_data),
    .lim_we_i(lim_we), .lim_ch_i(lim_ch), .lim_wdata_i(lim_wdata),
    .rd_ch_i(rd_ch), .rd_limit_o(rd_limit),
    .evt_we_i(evt_we), .evt_idx_i(evt_idx), .evt_wdata_i(evt_wdata), .evt_o(evt),
    .en_we_i(en_we), .en_wdata_i(en_wdata), .en_set_i(en_set), .en_clr_i(en_clr),
    .en_o(en_word), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_res(input int ch, input int val);
    @(negedge clk);
    res_vld = 1'b1; res_ch = 3'(ch); res_data = 16'(val);
    @(negedge clk);
    res_vld = 1'b0;
  endtask

  task automatic put_limit(input int ch, input int hi, input int lo);
    @(negedge clk);
    lim_we = 1'b1; lim_ch = 3'(ch); lim_wdata = {16'(hi), 16'(lo)};
    @(negedge clk);
    lim_we = 1'b0;
  endtask

  task automatic put_flag(input int idx, input bit val);
    @(negedge clk);
    evt_we = 1'b1; evt_idx = 4'(idx); evt_wdata = val;
    @(negedge clk);
    evt_we = 1'b0;
  endtask

  task automatic clear_flags();
    for (int k = 0; k < NEV; k++) put_flag(k, 1'b0);
  endtask

  task automatic put_en(input bit we, input logic [31:0] wd, input logic [31:0] s, input logic [31:0] c);
    @(negedge clk);
    en_we = we; en_wdata = wd; en_set = s; en_clr = c;
    @(negedge clk);
    en_we = 1'b0; en_wdata = '0; en_set = '0; en_clr = '0;
  endtask

  function automatic logic [15:0] exp_pair(input int ch, input int v, input int hi, input int lo);
    logic [15:0] e = '0;
    e[2*ch]   = (v >= hi);
    e[2*ch+1] = (v <= lo);
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    for (int c = 0; c < NCH; c++) begin
      rd_ch = 3'(c); #1;
      chk(rd_limit == 32'h7FFF8000, "R2 reset limit", rd_limit, 32'h7FFF8000);
    end
    chk(evt == '0, "R2 reset flags", 32'(evt), 0);
    chk(en_word == '0, "R2 reset enables", en_word, 0);
    chk(irq == 1'b0, "R2 reset irq", 32'(irq), 0);

    // R2/R3/R4: reset limits at the ends of the signed range
    put_res(3, 32766);
    chk(evt == '0, "R3 below reset high", 32'(evt), 0);
    put_res(3, 32767);
    chk(evt == 16'h0040, "R3 at reset high", 32'(evt), 32'h40);
    clear_flags();
    put_res(3, -32767);
    chk(evt == '0, "R4 above reset low", 32'(evt), 0);
    put_res(3, -32768);
    chk(evt == 16'h0080, "R4 at reset low", 32'(evt), 32'h80);
    clear_flags();

    // R8: enable placement via direct write
    put_en(1'b1, 32'hFFFF_FFFF, '0, '0);
    chk(en_word == 32'h003F_FFC0, "R8 enable field", en_word, 32'h003F_FFC0);

    // R1: limit layout and readback
    for (int c = 0; c < NCH; c++) put_limit(c, 4 + c, -3 - c);
    for (int c = 0; c < NCH; c++) begin
      rd_ch = 3'(c); #1;
      chk(rd_limit == {16'(4 + c), 16'(-3 - c)}, "R1 readback", rd_limit, {16'(4 + c), 16'(-3 - c)});
    end

    // R3 R4 R5 R10: sweep every channel across its window
    for (int c = 0; c < NCH; c++) begin
      for (int v = -12; v <= 14; v++) begin
        logic [15:0] e;
        e = exp_pair(c, v, 4 + c, -3 - c);
        put_res(c, v);
        chk(evt == e, "R3/R4/R5 sweep flags", 32'(evt), 32'(e));
        chk(irq == (|e), "R10 sweep irq", 32'(irq), 32'(|e));
        if (e != '0) clear_flags();
      end
    end

    // R11: strobe low has no effect
    @(negedge clk);
    res_ch = 3'd2; res_data = 16'(100);
    @(negedge clk);
    chk(evt == '0, "R11 no strobe", 32'(evt), 0);

    // R6: sticky, sw clear, sw set, hw wins
    put_res(1, 50);
    put_res(1, 0);
    chk(evt == 16'h0004, "R6 sticky", 32'(evt), 32'h4);
    put_flag(2, 1'b0);
    chk(evt == '0, "R6 sw clear", 32'(evt), 0);
    put_flag(9, 1'b1);
    chk(evt == 16'h0200, "R6 sw set", 32'(evt), 32'h200);
    put_flag(9, 1'b0);
    @(negedge clk);
    res_vld = 1'b1; res_ch = 3'd0; res_data = 16'(20);
    evt_we = 1'b1; evt_idx = 4'd0; evt_wdata = 1'b0;
    @(negedge clk);
    res_vld = 1'b0; evt_we = 1'b0;
    chk(evt == 16'h0001, "R6 hw wins", 32'(evt), 32'h1);
    clear_flags();

    // R7: inverted limits on channel 0 (hi -5, lo 5)
    put_limit(0, -5, 5);
    put_res(0, 0);
    chk(evt == 16'h0003, "R7 between both", 32'(evt), 32'h3);
    clear_flags();
    put_res(0, 10);
    chk(evt == 16'h0001, "R7 above", 32'(evt), 32'h1);
    clear_flags();
    put_res(0, -10);
    chk(evt == 16'h0002, "R7 below", 32'(evt), 32'h2);
    clear_flags();

    // R9: order write, set, clear
    put_en(1'b1, 32'h0000_0000, 32'h0000_0240, 32'h0000_0040);
    chk(en_word == 32'h0000_0200, "R9 write set clear", en_word, 32'h200);
    put_en(1'b0, '0, 32'h0000_0100, '0);
    chk(en_word == 32'h0000_0300, "R9 set keeps", en_word, 32'h300);
    put_en(1'b0, '0, '0, 32'h0000_0100);
    chk(en_word == 32'h0000_0200, "R9 clear", en_word, 32'h200);

    // R10: only bit 9 (channel 1 lower) enabled
    put_res(0, 100);
    chk(irq == 1'b0, "R10 masked", 32'(irq), 0);
    put_res(1, -100);
    chk(irq == 1'b1, "R10 enabled", 32'(irq), 1);
    put_flag(3, 1'b0);
    chk(irq == 1'b0, "R10 after clear", 32'(irq), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule